// File: doc/BRIEF.md
# Invalid-Block Scan Engine

At start-up this engine walks every block of a NAND array and finds the factory-marked unusable blocks. It sends single-byte read requests to a host sequencer and examines each returned byte. When a block is found bad, that block's bit is set in an on-chip bitmap. A block counts as bad as soon as any probed byte differs from the erased value FFh. The probed bytes are columns 0 and `SPARE_COL` of the first two pages of the block.

When the sweep ends, the engine reports the number of bad blocks and raises a fault flag in either of two cases: the first block, which should always be usable, reads bad, or too few good blocks remain. A combinational lookup port returns the bit for any block. An erase gate passes an erase request only after the scan has completed and only for a block whose bit is clear.

The read path is two valid/ready streams. The request channel carries a page address (block × `PAGES_PER_BLOCK` + page offset) and a column. The response channel carries one byte. Once the engine raises `rd_req_valid`, it keeps it high and holds `rd_req_page` and `rd_req_col` unchanged until `rd_req_ready` is seen high at a clock edge. The engine raises `rd_rsp_ready` only while it is waiting for the byte of a request that has been accepted. Response beats offered at any other time are dropped. At most one request is outstanding at a time.

Top module: `bad_block_scan`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `rd_req_valid` and `rd_rsp_ready` are low. `bad_count` is 0, every lookup bit reads 0, and every erase request is denied.
- R2: A request with `rd_req_valid` high and `rd_req_ready` low stays valid in the next cycle, with `rd_req_page` and `rd_req_col` unchanged.
- R3: Blocks are visited in ascending order. Within a block, the probes are issued in the order (page offset 0, column 0), (offset 0, column `SPARE_COL`), (offset 1, column 0), (offset 1, column `SPARE_COL`). The page address is block × `PAGES_PER_BLOCK` + offset.
- R4: The first returned byte that is not FFh marks the block bad. The remaining probes of that block are skipped, and the next request is the first probe of the next block. A block whose four bytes are all FFh stays clear.
- R5: A response beat is consumed only when `rd_rsp_ready` is high. A beat offered while `rd_rsp_ready` is low has no effect on the bitmap or on the count.
- R6: After the last block, `done` goes high and stays high until the next accepted start. At that point `busy` is low and `bad_count` equals the number of marked blocks.
- R7: `fault` is high exactly when `done` is high and either block 0 is marked bad or `bad_count` exceeds `NUM_BLOCKS - MIN_GOOD`.
- R8: `lk_bad` equals the bitmap bit of `lk_block` in the same cycle.
- R9: `er_grant` is high only when `er_valid` is high, `done` is high and the bit of `er_block` is clear. `er_deny` is high when `er_valid` is high and `er_grant` is low.
- R10: A `start` pulse while `busy` is high is ignored. A `start` pulse while idle or done clears the bitmap and the count, and restarts the sweep from block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished; results valid |
| bad_count | output | $clog2(NUM_BLOCKS+1) | Number of blocks marked bad |
| fault | output | 1 | Block 0 bad or too few good blocks |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Sequencer accepts request |
| rd_req_page | output | $clog2(NUM_BLOCKS*PAGES_PER_BLOCK) | Absolute page address |
| rd_req_col | output | $clog2(PAGE_BYTES) | Column of the byte to read |
| rd_rsp_valid | input | 1 | Read byte valid |
| rd_rsp_ready | output | 1 | Engine accepts read byte |
| rd_rsp_data | input | 8 | Read byte |
| lk_block | input | $clog2(NUM_BLOCKS) | Block to look up |
| lk_bad | output | 1 | Bitmap bit of `lk_block` |
| er_valid | input | 1 | Erase request present |
| er_block | input | $clog2(NUM_BLOCKS) | Block to erase |
| er_grant | output | 1 | Erase may proceed |
| er_deny | output | 1 | Erase refused |

## Verification
The bench targets the following cases:
- A bad byte at each of the four probe positions. An engine that did not stop early, or that probed in the wrong order, would produce a request stream that diverges from the expected one.
- Stray response beats while the engine is not waiting. An engine that consumed them would mark blocks that are actually good.
- A bad first block, and a bad-block count exactly at the limit and one past it. An off-by-one threshold would flip `fault`.
- A restart after a sweep. An engine that kept stale bits would report lookups, or grant erases, from the previous run.
- A start pulse in mid-sweep. An engine that honoured it would restart its probe sequence.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  localparam int PROBES_PER_BLOCK = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } bbs_state_e;
endpackage

// File: rtl/bbs_probe_addr.sv
module bbs_probe_addr #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int PAGE_BYTES      = 2112,
  parameter int SPARE_COL       = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK),
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic [BLK_W-1:0] blk,
  input  logic [1:0]       probe,
  output logic [PG_W-1:0]  page,
  output logic [COL_W-1:0] col
);
  // probe[1] selects the page offset, probe[0] the spare column
  always_comb begin
    page = PG_W'(blk) * PG_W'(PAGES_PER_BLOCK) + PG_W'(probe[1]);
    col  = probe[0] ? COL_W'(SPARE_COL) : '0;
  end
endmodule

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_idx,
  input  logic [BLK_W-1:0] lk_idx,
  output logic             lk_bit,
  input  logic [BLK_W-1:0] er_idx,
  output logic             er_bit,
  output logic             first_bit
);
  logic [NUM_BLOCKS-1:0] bits;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) bits <= '0;
    else if (set_en)   bits[set_idx] <= 1'b1;
  end

  assign lk_bit    = bits[lk_idx];
  assign er_bit    = bits[er_idx];
  assign first_bit = bits[0];

  // R4: each block is marked at most once per sweep
  a_r4_mark_once: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !bits[set_idx]);
endmodule

// File: rtl/bbs_ctrl.sv
module bbs_ctrl
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] bad_count,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [7:0]       rsp_data,
  output logic [BLK_W-1:0] blk,
  output logic [1:0]       probe,
  output logic             clr,
  output logic             set_en
);
  localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [1:0]       LAST_PROBE = 2'(PROBES_PER_BLOCK - 1);

  bbs_state_e state;
  logic       take, byte_bad;

  assign req_valid = (state == ST_REQ);
  assign rsp_ready = (state == ST_WAIT);
  assign busy      = (state == ST_REQ) || (state == ST_WAIT);
  assign done      = (state == ST_DONE);
  assign clr       = start && !busy;
  assign take      = rsp_ready && rsp_valid;
  assign byte_bad  = (rsp_data != ERASED_BYTE);
  assign set_en    = take && byte_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      blk       <= '0;
      probe     <= '0;
      bad_count <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state     <= ST_REQ;
          blk       <= '0;
          probe     <= '0;
          bad_count <= '0;
        end
        ST_REQ: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (byte_bad || probe == LAST_PROBE) begin
            if (byte_bad) bad_count <= bad_count + CNT_W'(1);
            probe <= '0;
            if (blk == LAST_BLK) state <= ST_DONE;
            else begin
              blk   <= blk + BLK_W'(1);
              state <= ST_REQ;
            end
          end else begin
            probe <= probe + 2'd1;
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: results stay up until a new sweep is started
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(bad_count));
  // R10: a start while busy does not rewind the sweep
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !take |=> $stable(blk) && $stable(probe));
endmodule

// File: rtl/bad_block_scan.sv
module bad_block_scan #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int PAGE_BYTES      = 2112,
  parameter int SPARE_COL       = 2048,
  parameter int MIN_GOOD        = 2008,
  localparam int BLK_W   = $clog2(NUM_BLOCKS),
  localparam int PG_W    = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK),
  localparam int COL_W   = $clog2(PAGE_BYTES),
  localparam int CNT_W   = $clog2(NUM_BLOCKS + 1),
  localparam int MAX_BAD = NUM_BLOCKS - MIN_GOOD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] bad_count,
  output logic             fault,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [PG_W-1:0]  rd_req_page,
  output logic [COL_W-1:0] rd_req_col,
  input  logic             rd_rsp_valid,
  output logic             rd_rsp_ready,
  input  logic [7:0]       rd_rsp_data,
  input  logic [BLK_W-1:0] lk_block,
  output logic             lk_bad,
  input  logic             er_valid,
  input  logic [BLK_W-1:0] er_block,
  output logic             er_grant,
  output logic             er_deny
);
  logic [BLK_W-1:0] blk;
  logic [1:0]       probe;
  logic             clr, set_en, er_bit, first_bit;

  bbs_ctrl #(.NUM_BLOCKS(NUM_BLOCKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .bad_count(bad_count), .req_valid(rd_req_valid), .req_ready(rd_req_ready),
    .rsp_valid(rd_rsp_valid), .rsp_ready(rd_rsp_ready), .rsp_data(rd_rsp_data),
    .blk(blk), .probe(probe), .clr(clr), .set_en(set_en)
  );

  bbs_probe_addr #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .PAGE_BYTES(PAGE_BYTES), .SPARE_COL(SPARE_COL)
  ) u_addr (
    .blk(blk), .probe(probe), .page(rd_req_page), .col(rd_req_col)
  );

  bbs_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .clk(clk), .rst_n(rst_n), .clr(clr), .set_en(set_en), .set_idx(blk),
    .lk_idx(lk_block), .lk_bit(lk_bad), .er_idx(er_block), .er_bit(er_bit),
    .first_bit(first_bit)
  );

  assign fault    = done && (first_bit || (int'(bad_count) > MAX_BAD));
  assign er_grant = er_valid && done && !er_bit;
  assign er_deny  = er_valid && !er_grant;

  // R2: request held stable under back-pressure
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=>
      rd_req_valid && $stable(rd_req_page) && $stable(rd_req_col));
  // R3: only columns 0 and the spare column, only page offsets 0 and 1
  a_r3_probe_col: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_col == '0) || (int'(rd_req_col) == SPARE_COL));
  a_r3_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (int'(rd_req_page) % PAGES_PER_BLOCK) < 2);
  // R5: never a request and an open response slot together
  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));
endmodule

// File: tb/tb_bad_block_scan.sv
module tb_bad_block_scan;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 128;
  localparam int PPB  = 64;
  localparam int SPR  = 2048;
  localparam int MING = 120;
  localparam int BLK_W = $clog2(NB);
  localparam int PG_W  = $clog2(NB * PPB);
  localparam int COL_W = $clog2(2112);
  localparam int CNT_W = $clog2(NB + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, fault, rd_req_valid, rd_req_ready = 0;
  logic [CNT_W-1:0] bad_count;
  logic [PG_W-1:0]  rd_req_page;
  logic [COL_W-1:0] rd_req_col;
  logic rd_rsp_valid = 0, rd_rsp_ready;
  logic [7:0] rd_rsp_data = 8'hFF;
  logic [BLK_W-1:0] lk_block = '0, er_block = '0;
  logic lk_bad, er_valid = 0, er_grant, er_deny;

  always #(CLK_PERIOD/2) clk = ~clk;

  bad_block_scan #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .PAGE_BYTES(2112),
                   .SPARE_COL(SPR), .MIN_GOOD(MING)) dut (.*);

  int checks = 0, fails = 0;
  int bad_at [NB];       // probe index of first bad byte, 4 = good block
  int order_err = 0, exp_blk = 0, exp_idx = 0;
  bit stub_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count();
    int n = 0;
    for (int b = 0; b < NB; b++) if (bad_at[b] < 4) n++;
    return n;
  endfunction

  function automatic bit exp_fault();
    return (bad_at[0] < 4) || (exp_count() > NB - MING);
  endfunction

  // sequencer stub, all activity on the falling edge
  initial begin
    bit fire_req = 0, fire_rsp = 0, pend = 0;
    int dly = 0, cb = 0, ci = 0;
    logic [7:0] rbyte = 8'hFF;
    forever begin
      @(negedge clk);
      if (fire_rsp) begin
        pend = 0;
        if (rbyte != 8'hFF || exp_idx == 3) begin exp_blk++; exp_idx = 0; end
        else exp_idx++;
      end
      if (fire_req) begin
        if (cb != exp_blk || ci != exp_idx) order_err++;
        pend  = 1;
        dly   = $urandom % 3;
        rbyte = (ci == bad_at[cb]) ? 8'($urandom % 255) : 8'hFF;
      end
      rd_req_ready = stub_on && ($urandom % 4 != 0);
      if (pend) begin
        rd_rsp_valid = (dly == 0);
        rd_rsp_data  = rbyte;
        if (dly > 0) dly--;
      end else if (!rd_rsp_ready && ($urandom % 6 == 0)) begin
        rd_rsp_valid = 1;            // stray beat, must be ignored (R5)
        rd_rsp_data  = 8'h00;
      end else rd_rsp_valid = 0;
      fire_req = rd_req_valid && rd_req_ready;
      if (fire_req) begin
        cb = int'(rd_req_page) / PPB;
        ci = (int'(rd_req_page) % PPB) * 2 + ((int'(rd_req_col) == SPR) ? 1 : 0);
      end
      fire_rsp = rd_rsp_valid && rd_rsp_ready;
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    exp_blk = 0; exp_idx = 0; order_err = 0; stub_on = 1;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_scan(input string name, input bit poke_mid);
    int cyc = 0;
    pulse_start();
    chk(busy && bad_count == 0, "R10 restart clears count", int'(bad_count), 0);
    lk_block = '0; #1;
    chk(!lk_bad, "R10 restart clears bitmap", lk_bad, 0);
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke_mid && cyc == 300) begin start = 1; @(negedge clk); start = 0; end
      if (cyc == 50) begin
        er_valid = 1; er_block = BLK_W'(NB - 1); #1;
        chk(!er_grant && er_deny, "R9 erase denied mid-sweep", er_grant, 0);
        er_valid = 0;
      end
    end
    chk(done, {"R6 done reached ", name}, done, 1);
    chk(!busy, "R6 busy low at done", busy, 0);
    chk(order_err == 0, {"R3 R4 probe order ", name}, order_err, 0);
    chk(int'(bad_count) == exp_count(), {"R6 bad count ", name}, int'(bad_count), exp_count());
    chk(fault == exp_fault(), {"R7 fault ", name}, fault, exp_fault());
    begin
      int mism = 0;
      for (int b = 0; b < NB; b++) begin
        lk_block = BLK_W'(b); #1;
        if (lk_bad != (bad_at[b] < 4)) mism++;
      end
      chk(mism == 0, {"R8 lookup sweep ", name}, mism, 0);
    end
    for (int b = 0; b < NB; b++) begin
      if (b == 0 || b == NB - 1 || bad_at[b] < 4) begin
        er_valid = 1; er_block = BLK_W'(b); #1;
        chk(er_grant == (bad_at[b] == 4) && er_deny == (bad_at[b] < 4),
            "R9 erase gate", er_grant, bad_at[b] == 4);
      end
    end
    er_valid = 0;
    repeat (3) @(negedge clk);
    chk(done, "R6 done held", done, 1);
  endtask

  initial begin
    process::self().srandom(32'h5EED_0042);
    for (int b = 0; b < NB; b++) bad_at[b] = 4;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !fault && !rd_req_valid && !rd_rsp_ready,
        "R1 idle outputs", busy, 0);
    chk(bad_count == 0, "R1 count", int'(bad_count), 0);
    lk_block = BLK_W'(5); er_valid = 1; er_block = BLK_W'(5); #1;
    chk(!lk_bad && !er_grant && er_deny, "R1 lookup and erase", er_grant, 0);
    er_valid = 0;

    // random pattern, mid-sweep start must be ignored
    for (int b = 1; b < NB; b++) bad_at[b] = ($urandom % 20 == 0) ? int'($urandom % 4) : 4;
    run_scan("random", 1);

    // each probe position, plus last block
    for (int b = 0; b < NB; b++) bad_at[b] = 4;
    bad_at[1] = 0; bad_at[2] = 1; bad_at[3] = 2; bad_at[4] = 3; bad_at[NB-1] = 1;
    run_scan("positions", 0);

    // first block bad
    for (int b = 0; b < NB; b++) bad_at[b] = 4;
    bad_at[0] = 2;
    run_scan("block0", 0);

    // exactly at the limit, then one past
    for (int b = 0; b < NB; b++) bad_at[b] = 4;
    for (int k = 0; k < NB - MING; k++) bad_at[10 + k * 9] = k % 4;
    run_scan("limit", 0);
    bad_at[NB - 2] = 0;
    run_scan("over limit", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule